// File: doc/BRIEF.md
# PCIe Root Port Interrupt Aggregator

This block gathers the interrupt sources of a PCIe root port bridge into one 32-bit status word and drives a single level-sensitive interrupt line to the host. Two kinds of source feed it. Six root-complex event pulses latch into sticky status bits. Four legacy INTx lines appear as live levels in an 8-bit field. An interrupt is pending when its status bit is set and its mask bit is clear. The output goes high one cycle after any interrupt becomes pending.

Software reaches the block over a plain 32-bit register bus with separate read and write strobes. The mask cannot be written directly. Software unmasks a source by writing a one to the enable register and masks it by writing a one to the disable register. Zero bits leave the mask as it was, so two drivers that share the mask never have to read, modify and write it. Software reads the status, ANDs it with the inverted mask, services the sources and writes the value it read back to the status register.

Top module: `rp_irq_hub`

## Requirements
- R1: After reset every status bit reads 0, the mask register reads 0xFFFFFFFF and `irq_o` is 0.
- R2: A high cycle on `rc_evt_i[k]` sets a sticky status bit at the clock edge that samples it. The bit positions are: k=0 completion timeout at bit 15, k=1 power-management event message at bit 24, k=2 turn-off acknowledge at bit 25, k=3 correctable error at bit 26, k=4 non-fatal error at bit 27, k=5 fatal error at bit 28.
- R3: A write to the status register (offset 0x4C0) clears each event bit whose data bit is 1. Event bits whose data bit is 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 16+2n shows the level of `intx_lvl_i[n]` (INTA to INTD for n=0..3), delayed by one register stage. It follows the line both up and down. Bits 17, 19, 21 and 23 read 0.
- R6: A clearing write to an INTx status bit has no effect. The bit stays 1 while its line is asserted.
- R7: A write to the enable register (offset 0x4C8) clears the mask bit of every implemented source whose data bit is 1. Other mask bits are unchanged. The mask changes only on writes to the enable or disable register.
- R8: A write to the disable register (offset 0x4CC) sets each mask bit whose data bit is 1. Other mask bits are unchanged.
- R9: `irq_o` is the registered OR of (status AND NOT mask). It rises on the cycle after a bit becomes pending and stays high until every pending bit is cleared or masked.
- R10: A masked source still sets its status bit. Unmasking it later raises `irq_o`.
- R11: Unimplemented status bits always read 0. Unimplemented mask bits always read 1, and enable writes cannot change them.
- R12: The mask register reads at offset 0x4C4. A read strobe returns its data on `bus_rdata` after the next clock edge, and the value holds until the next read. Reads at the enable offset, the disable offset or any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| rc_evt_i | input | 6 | Root-complex event pulses, mapped as in R2 |
| intx_lvl_i | input | 4 | Legacy INTA..INTD assert levels |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The assertions check on every cycle that event pulses latch, that latched events hold unless a clearing write hits them, that the INTx bits track their lines and that the mask moves only through the enable and disable registers. They also check that the output follows pending state with one cycle of delay and that unimplemented bits stay fixed. Some behaviour only the bench scenarios can show. These are the register read path and its offsets, and the absolute bit map a driver depends on. The others are the set-versus-clear collision from software's point of view and the full sequence of masked capture, later unmask and write-back clear.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

    localparam int DATA_W     = 32;
    localparam int N_EVT      = 6;
    localparam int N_INTX     = 4;
    localparam int INTX_LSB   = 16;
    localparam int INTX_FLD_W = 2 * N_INTX;

    // status bit of each event input, index = input bit
    localparam int EVT_POS [N_EVT] = '{15, 24, 25, 26, 27, 28};

    typedef logic [DATA_W-1:0] word_t;

    function automatic word_t evt_bits();
        word_t m = '0;
        for (int i = 0; i < N_EVT; i++) m[EVT_POS[i]] = 1'b1;
        return m;
    endfunction

    function automatic word_t intx_bits();
        word_t m = '0;
        for (int n = 0; n < N_INTX; n++) m[INTX_LSB + 2*n] = 1'b1;
        return m;
    endfunction

    function automatic word_t impl_bits();
        return evt_bits() | intx_bits();
    endfunction

endpackage

// File: rtl/rp_irq_regif.sv
module rp_irq_regif
    import rp_irq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFS_STAT = 'h4C0,
    parameter int OFS_MASK = 'h4C4,
    parameter int OFS_EN   = 'h4C8,
    parameter int OFS_DIS  = 'h4CC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  word_t             stat_i,
    input  word_t             mask_i,
    output logic              wr_stat_o,
    output logic              wr_en_o,
    output logic              wr_dis_o,
    output word_t             rdata_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);

    typedef struct packed {
        word_t rdata;
    } rif_t;

    rif_t rif_d, rif_q;

    always_comb begin
        rif_d     = rif_q;
        wr_stat_o = bus_wr && (bus_addr == A_STAT);
        wr_en_o   = bus_wr && (bus_addr == A_EN);
        wr_dis_o  = bus_wr && (bus_addr == A_DIS);
        if (bus_rd) begin
            unique case (bus_addr)
                A_STAT:  rif_d.rdata = stat_i;
                A_MASK:  rif_d.rdata = mask_i;
                default: rif_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rif_q <= '0;
        else        rif_q <= rif_d;
    end

    assign rdata_o = rif_q.rdata;

endmodule

// File: rtl/rp_irq_status.sv
module rp_irq_status
    import rp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_EVT-1:0]  evt_i,
    input  logic [N_INTX-1:0] intx_i,
    input  logic [N_EVT-1:0]  clr_i,
    output word_t             stat_o
);
    typedef struct packed {
        logic [N_EVT-1:0]  evt;
        logic [N_INTX-1:0] lvl;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_EVT; i++) begin
            if (clr_i[i]) st_d.evt[i] = 1'b0;
            if (evt_i[i]) st_d.evt[i] = 1'b1;   // a new event beats a clear
        end
        st_d.lvl = intx_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        stat_o = '0;
        for (int i = 0; i < N_EVT; i++)  stat_o[EVT_POS[i]]       = st_q.evt[i];
        for (int n = 0; n < N_INTX; n++) stat_o[INTX_LSB + 2*n]   = st_q.lvl[n];
    end

endmodule

// File: rtl/rp_irq_mask.sv
module rp_irq_mask
    import rp_irq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en_i,
    input  logic  wr_dis_i,
    input  word_t wdata_i,
    output word_t mask_o
);
    localparam word_t IMPL = impl_bits();

    typedef struct packed {
        word_t mask;
    } msk_t;

    msk_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_dis_i) m_d.mask = m_d.mask | wdata_i;
        if (wr_en_i)  m_d.mask = m_d.mask & ~(wdata_i & IMPL);
        m_d.mask = m_d.mask | ~IMPL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '1;
        else        m_q <= m_d;
    end

    assign mask_o = m_q.mask;

endmodule

// File: rtl/rp_irq_hub.sv
module rp_irq_hub
    import rp_irq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFS_STAT = 'h4C0,
    parameter int OFS_MASK = 'h4C4,
    parameter int OFS_EN   = 'h4C8,
    parameter int OFS_DIS  = 'h4CC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        rc_evt_i,
    input  logic [3:0]        intx_lvl_i,
    output logic              irq_o
);
    word_t            stat_q;
    word_t            mask_q;
    logic             wr_stat;
    logic             wr_en;
    logic             wr_dis;
    logic [N_EVT-1:0] evt_clr;

    typedef struct packed {
        logic irq;
    } out_t;

    out_t o_d, o_q;

    rp_irq_regif #(
        .ADDR_W  (ADDR_W),
        .OFS_STAT(OFS_STAT),
        .OFS_MASK(OFS_MASK),
        .OFS_EN  (OFS_EN),
        .OFS_DIS (OFS_DIS)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .stat_i   (stat_q),
        .mask_i   (mask_q),
        .wr_stat_o(wr_stat),
        .wr_en_o  (wr_en),
        .wr_dis_o (wr_dis),
        .rdata_o  (bus_rdata)
    );

    always_comb begin
        for (int i = 0; i < N_EVT; i++) evt_clr[i] = wr_stat && bus_wdata[EVT_POS[i]];
    end

    rp_irq_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (rc_evt_i),
        .intx_i(intx_lvl_i),
        .clr_i (evt_clr),
        .stat_o(stat_q)
    );

    rp_irq_mask u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .wr_dis_i(wr_dis),
        .wdata_i (bus_wdata),
        .mask_o  (mask_q)
    );

    always_comb begin
        o_d     = o_q;
        o_d.irq = |(stat_q & ~mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o = o_q.irq;

endmodule

// File: rtl/rp_irq_hub_chk.sv
module rp_irq_hub_chk
    import rp_irq_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int OFS_STAT = 'h4C0,
    parameter int OFS_EN   = 'h4C8,
    parameter int OFS_DIS  = 'h4CC
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [5:0]        rc_evt_i,
    input logic [3:0]        intx_lvl_i,
    input logic              irq_o,
    input logic [31:0]       stat_q,
    input logic [31:0]       mask_q
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DIS);
    localparam word_t             IMPL   = impl_bits();

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    logic wr_st, wr_en, wr_dis;
    assign wr_st  = bus_wr && (bus_addr == A_STAT);
    assign wr_en  = bus_wr && (bus_addr == A_EN);
    assign wr_dis = bus_wr && (bus_addr == A_DIS);

    for (genvar i = 0; i < N_EVT; i++) begin : g_evt
        AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
            rc_evt_i[i] |=> stat_q[EVT_POS[i]]); // R2
        AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (stat_q[EVT_POS[i]] && !(wr_st && bus_wdata[EVT_POS[i]])) |=> stat_q[EVT_POS[i]]); // R3
        AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_st && bus_wdata[EVT_POS[i]] && !rc_evt_i[i]) |=> !stat_q[EVT_POS[i]]); // R3
    end

    for (genvar n = 0; n < N_INTX; n++) begin : g_intx
        AST_INTX_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> (stat_q[INTX_LSB + 2*n] == $past(intx_lvl_i[n]))); // R5
    end

    AST_MASK_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((mask_q & $past(bus_wdata) & IMPL) == '0)); // R7
    AST_MASK_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dis |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R8
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || wr_dis) |=> $stable(mask_q)); // R7
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_q & ~mask_q)) |=> irq_o); // R9
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(stat_q & ~mask_q)) |=> !irq_o); // R9
    AST_UNIMPL_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~IMPL) == '0) && ((mask_q | IMPL) == '1)); // R11

endmodule

bind rp_irq_hub rp_irq_hub_chk #(
    .ADDR_W  (ADDR_W),
    .OFS_STAT(OFS_STAT),
    .OFS_EN  (OFS_EN),
    .OFS_DIS (OFS_DIS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rc_evt_i  (rc_evt_i),
    .intx_lvl_i(intx_lvl_i),
    .irq_o     (irq_o),
    .stat_q    (stat_q),
    .mask_q    (mask_q)
);

// File: tb/rp_irq_hub_bench.sv
module rp_irq_hub_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam logic [ADDR_W-1:0] A_STAT = 12'h4C0;
    localparam logic [ADDR_W-1:0] A_MASK = 12'h4C4;
    localparam logic [ADDR_W-1:0] A_EN   = 12'h4C8;
    localparam logic [ADDR_W-1:0] A_DIS  = 12'h4CC;
    // implemented bits: 15, 16/18/20/22, 24..28
    localparam logic [31:0] IMPL = 32'h1F55_8000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [5:0]        rc_evt_i = '0;
    logic [3:0]        intx_lvl_i = '0;
    logic              irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_irq_hub u_rp_irq_hub (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rc_evt_i  (rc_evt_i),
        .intx_lvl_i(intx_lvl_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_evt(input logic [5:0] v);
        @(negedge clk);
        rc_evt_i = v;
        @(negedge clk);
        rc_evt_i = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        bus_read(A_STAT, d);
        check("R1 status after reset", d, 32'h0);
        bus_read(A_MASK, d);
        check("R1 mask after reset", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_events();
        logic [31:0] d;
        pulse_evt(6'b000001);
        bus_read(A_STAT, d);
        check("R2 completion timeout at bit 15", d, 32'h0000_8000);
        pulse_evt(6'b111110);
        bus_read(A_STAT, d);
        check("R2 events at bits 24..28", d, 32'h1F00_8000);
        check("R10 masked events keep irq low", {31'b0, irq_o}, 32'h0);
        bus_write(A_STAT, 32'h0500_0000);
        bus_read(A_STAT, d);
        check("R3 clear bits 24 and 26 only", d, 32'h1A00_8000);
        bus_write(A_STAT, 32'h1A00_8000);
        bus_read(A_STAT, d);
        check("R3 write back clears all", d, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0000_8000;
        rc_evt_i = 6'b000001;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; rc_evt_i = '0;
        bus_read(A_STAT, d);
        check("R4 set beats clear", d, 32'h0000_8000);
        bus_write(A_STAT, 32'h0000_8000);
        bus_read(A_STAT, d);
        check("R4 later clear works", d, 32'h0);
    endtask

    task automatic t_intx();
        logic [31:0] d;
        @(negedge clk);
        intx_lvl_i = 4'b0010;
        @(negedge clk);
        bus_read(A_STAT, d);
        check("R5 INTB at bit 18", d, 32'h0004_0000);
        intx_lvl_i = 4'b1111;
        @(negedge clk);
        bus_read(A_STAT, d);
        check("R5 all lines, odd bits zero", d, 32'h0055_0000);
        bus_write(A_STAT, 32'h00FF_0000);
        bus_read(A_STAT, d);
        check("R6 clear ignored while asserted", d, 32'h0055_0000);
        intx_lvl_i = 4'b0000;
        @(negedge clk);
        bus_read(A_STAT, d);
        check("R5 bits follow line low", d, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_write(A_EN, 32'h0);
        bus_read(A_MASK, d);
        check("R7 enable with zeros no change", d, 32'hFFFF_FFFF);
        bus_write(A_EN, 32'hFFFF_FFFF);
        bus_read(A_MASK, d);
        check("R11 unimplemented mask bits stay 1", d, ~IMPL);
        bus_write(A_DIS, 32'h0800_0000);
        bus_read(A_MASK, d);
        check("R8 disable sets bit 27", d, ~IMPL | 32'h0800_0000);
        bus_write(A_DIS, 32'h0);
        bus_read(A_MASK, d);
        check("R8 disable with zeros no change", d, ~IMPL | 32'h0800_0000);
        bus_read(A_EN, d);
        check("R12 enable offset reads 0", d, 32'h0);
        bus_read(A_DIS, d);
        check("R12 disable offset reads 0", d, 32'h0);
        bus_read(12'h100, d);
        check("R12 unmapped offset reads 0", d, 32'h0);
        bus_write(A_STAT, 32'hFFFF_FFFF);
        bus_read(A_STAT, d);
        check("R11 unimplemented status bits 0", d, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        // mask: bit 27 masked, rest enabled
        pulse_evt(6'b010000);
        bus_read(A_STAT, d);
        check("R10 masked event still latched", d, 32'h0800_0000);
        check("R10 masked source keeps irq low", {31'b0, irq_o}, 32'h0);
        bus_write(A_EN, 32'h0800_0000);
        check("R10 unmask raises irq", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 irq one cycle after unmask", {31'b0, irq_o}, 32'h1);
        bus_write(A_STAT, 32'h0800_0000);
        @(negedge clk);
        check("R9 irq falls after clear", {31'b0, irq_o}, 32'h0);
        pulse_evt(6'b000001);
        check("R9 irq not yet high", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R9 irq rises one cycle later", {31'b0, irq_o}, 32'h1);
        repeat (3) @(negedge clk);
        check("R9 irq holds while pending", {31'b0, irq_o}, 32'h1);
        bus_write(A_DIS, 32'h0000_8000);
        @(negedge clk);
        check("R9 irq falls when masked", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        intx_lvl_i = 4'b0100;
        repeat (3) @(negedge clk);
        check("R9 INTC pending drives irq", {31'b0, irq_o}, 32'h1);
        intx_lvl_i = 4'b0000;
        repeat (3) @(negedge clk);
        check("R9 irq drops with INTC line", {31'b0, irq_o}, 32'h0);
    endtask

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_set_wins();
        t_intx();
        t_mask();
        t_irq();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule